// File: doc/BRIEF.md
# Half-Bridge Gate Command Logic

This block turns four per-switch commands into four gate-enable bits for two half bridges (the leg count is a parameter). The high-side command of each leg is active low and the low-side command is active high. Because of that, a single control wire tied to both command inputs of one leg drives that leg as a complementary pair. In its protected mode the block refuses any request to turn on both switches of one leg. It also enforces a fixed gap, counted in clock cycles, during which both switches of a leg stay off before either one turns on.

A global enable and a force-off input from the diagnostic logic both blank every gate at once. A bypass request suits loads wired across one leg. Once it has been held long enough to pass a cycle-count filter, it removes both the lockout and the gap, and each gate then follows its own command. When the bypass request drops, every gate is cleared and a full gap runs before protected decoding resumes.

Top module: `hb_gate_ctrl`

## Requirements
- R1: Bit i of every vector belongs to leg i. hs_cmd_n[i]=0 requests the high switch of leg i and ls_cmd[i]=1 requests its low switch. When a request is made to an idle leg whose gap has elapsed, the matching gate (hs_gate[i] or ls_gate[i]) goes to 1 at the next clock edge. A withdrawn request drops its gate at the next edge.
- R2: While enable is 0, all gates are 0 in the same cycle, and the internal switch state is cleared. A gate that was on before enable fell waits a full gap after enable returns.
- R3: While force_off is 1, all gates are 0 in the same cycle with no gap delay, and the switch state is cleared exactly as for R2.
- R4: In protected mode, a request for both switches of one leg at once is ignored, and that leg keeps the gate values it already had.
- R5: In protected mode, a gate rises only after both gates of its leg have been 0 for DEAD_CYC consecutive cycles. The count starts at the edge that turned the partner off.
- R6: With hs_cmd_n[i] and ls_cmd[i] tied together, the leg's two gates are complementary, with a DEAD_CYC-cycle gap at each change of direction.
- R7: Bypass takes effect only at the FILT_CYC-th consecutive clock edge that samples bypass_req high. A shorter pulse leaves protected mode untouched.
- R8: In bypass, each gate follows its own request one edge later. Both gates of a leg may be on together, and no gap is inserted.
- R9: The first edge that samples bypass_req low clears all gates. Protected decoding then resumes, and a gate may rise only after DEAD_CYC cycles with all gates of its leg off.
- R10: During reset all gates are 0. The first request after reset is honoured at the next edge, with no gap wait.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| enable | input | 1 | Global enable, gates blanked while 0 |
| force_off | input | 1 | Immediate turn-off from diagnostic logic |
| bypass_req | input | 1 | Request to drop lockout and gap, filtered |
| hs_cmd_n | input | LEGS | High-side commands, active low |
| ls_cmd | input | LEGS | Low-side commands, active high |
| hs_gate | output | LEGS | High-side gate enables |
| ls_gate | output | LEGS | Low-side gate enables |

## Verification
The hardest state to reach is the change back from bypass to protected mode while both switches of one leg are on. Reaching it takes a bypass request held for the full filter count, followed by commands that a protected leg would refuse. The stimulus first sends a pulse one edge shorter than the filter and shows that a conflicting command is still held. It then holds the request for the full count, turns on both switches of a leg, and moves the other leg between its switches with no gap. Finally it drops the request and counts the blanked cycles until protected decoding resumes.

// File: rtl/hbc_pkg.sv
package hbc_pkg;

   typedef struct packed {
      logic hi;
      logic lo;
   } leg_pair_t;

   typedef enum logic [1:0] {
      MODE_NORM = 2'd0,
      MODE_BYP  = 2'd1,
      MODE_EXIT = 2'd2,
      MODE_KILL = 2'd3
   } leg_mode_t;

   function automatic int unsigned cnt_w(input int unsigned n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction

endpackage

// File: rtl/hbc_cmd_decode.sv
module hbc_cmd_decode
   import hbc_pkg::*;
#(
   parameter int unsigned LEGS = 2
) (
   input  logic                  enable,
   input  logic                  force_off,
   input  logic [LEGS-1:0]       hs_cmd_n,
   input  logic [LEGS-1:0]       ls_cmd,
   output leg_pair_t [LEGS-1:0]  req,
   output logic                  kill
);

   assign kill = ~enable | force_off;

   for (genvar i = 0; i < LEGS; i++) begin : g_leg
      assign req[i].hi = ~hs_cmd_n[i];
      assign req[i].lo = ls_cmd[i];
   end

endmodule

// File: rtl/hbc_bypass_filter.sv
module hbc_bypass_filter
   import hbc_pkg::*;
#(
   parameter int unsigned FILT_CYC = 200
) (
   input  logic clk,
   input  logic rst_n,
   input  logic req,
   output logic byp_act,
   output logic byp_exit
);

   localparam int unsigned FW = cnt_w(FILT_CYC);
   localparam logic [FW-1:0] FMAX = FW'(FILT_CYC - 1);

   logic [FW-1:0] fcnt_q, fcnt_d;
   logic          byp_q, byp_d;

   always_comb begin
      if (!req)
         fcnt_d = '0;
      else if (fcnt_q != FMAX)
         fcnt_d = fcnt_q + 1'b1;
      else
         fcnt_d = fcnt_q;
      byp_d = req & (byp_q | (fcnt_q == FMAX));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fcnt_q <= '0;
         byp_q  <= 1'b0;
      end else begin
         fcnt_q <= fcnt_d;
         byp_q  <= byp_d;
      end
   end

   assign byp_act  = byp_q;
   assign byp_exit = byp_q & ~req;

   // R7: bypass only starts after a full run of high samples
   assert_filter_full_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(byp_q) |-> ($past(fcnt_q) == FMAX) && $past(req));

   // R7: bypass never persists past a low sample
   assert_filter_drop_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !req |=> !byp_q);

endmodule

// File: rtl/hbc_leg.sv
module hbc_leg
   import hbc_pkg::*;
#(
   parameter int unsigned DEAD_CYC = 11
) (
   input  logic      clk,
   input  logic      rst_n,
   input  leg_pair_t req,
   input  logic      kill,
   input  logic      byp_act,
   input  logic      byp_exit,
   output leg_pair_t gate
);

   localparam int unsigned CW = cnt_w(DEAD_CYC);
   localparam logic [CW-1:0] CNT_RDY = CW'(DEAD_CYC - 1);

   leg_pair_t     st_q, st_d;
   logic [CW-1:0] gap_q, gap_d;
   logic          gap_ok;
   logic          clash;
   leg_mode_t     mode;

   assign gap_ok = (gap_q == CNT_RDY);
   assign clash  = req.hi & req.lo;

   always_comb begin
      if (kill)
         mode = MODE_KILL;
      else if (byp_exit)
         mode = MODE_EXIT;
      else if (byp_act)
         mode = MODE_BYP;
      else
         mode = MODE_NORM;
   end

   always_comb begin
      st_d = st_q;
      unique case (mode)
         MODE_KILL, MODE_EXIT: st_d = '0;
         MODE_BYP:             st_d = req;
         MODE_NORM: begin
            if (!clash) begin
               st_d.hi = req.hi & (st_q.hi | (~st_q.lo & gap_ok));
               st_d.lo = req.lo & (st_q.lo | (~st_q.hi & gap_ok));
            end
         end
         default:              st_d = '0;
      endcase
   end

   always_comb begin
      if (byp_exit || st_q.hi || st_q.lo)
         gap_d = '0;
      else if (!gap_ok)
         gap_d = gap_q + 1'b1;
      else
         gap_d = gap_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q  <= '0;
         gap_q <= CNT_RDY;
      end else begin
         st_q  <= st_d;
         gap_q <= gap_d;
      end
   end

   assign gate.hi = st_q.hi & ~kill;
   assign gate.lo = st_q.lo & ~kill;

   // R4: outside bypass the two switches are never on together
   assert_no_overlap_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !byp_act |-> !(st_q.hi && st_q.lo));

   // R4: a conflicting request leaves the state untouched
   assert_clash_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (!kill && !byp_act && req.hi && req.lo) |=> $stable(st_q));

   // R5: a protected turn-on only follows a completed gap
   assert_gap_hi_R5: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(st_q.hi) && !$past(byp_act)) |-> ($past(gap_q) == CNT_RDY) && !$past(st_q.lo));

   assert_gap_lo_R5: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(st_q.lo) && !$past(byp_act)) |-> ($past(gap_q) == CNT_RDY) && !$past(st_q.hi));

   // R3: a blanked cycle leaves no switch on
   assert_kill_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
      kill |=> (st_q == '0));

   // R8: in bypass the state copies the request
   assert_byp_follow_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (byp_act && !byp_exit && !kill) |=> (st_q == $past(req)));

   // R9: leaving bypass clears the switches and restarts the gap
   assert_exit_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
      byp_exit |=> (st_q == '0) && (gap_q == '0));

endmodule

// File: rtl/hb_gate_ctrl.sv
module hb_gate_ctrl
   import hbc_pkg::*;
#(
   parameter int unsigned LEGS     = 2,
   parameter int unsigned DEAD_CYC = 11,
   parameter int unsigned FILT_CYC = 200
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            enable,
   input  logic            force_off,
   input  logic            bypass_req,
   input  logic [LEGS-1:0] hs_cmd_n,
   input  logic [LEGS-1:0] ls_cmd,
   output logic [LEGS-1:0] hs_gate,
   output logic [LEGS-1:0] ls_gate
);

   if (LEGS < 1) begin : g_bad_legs
      $error("hb_gate_ctrl: LEGS must be at least 1");
   end
   if (DEAD_CYC < 1) begin : g_bad_dead
      $error("hb_gate_ctrl: DEAD_CYC must be at least 1");
   end
   if (FILT_CYC < 1) begin : g_bad_filt
      $error("hb_gate_ctrl: FILT_CYC must be at least 1");
   end

   leg_pair_t [LEGS-1:0] req;
   leg_pair_t [LEGS-1:0] gate;
   logic                 kill;
   logic                 byp_act;
   logic                 byp_exit;

   hbc_cmd_decode #(
      .LEGS (LEGS)
   ) u_decode (
      .enable    (enable),
      .force_off (force_off),
      .hs_cmd_n  (hs_cmd_n),
      .ls_cmd    (ls_cmd),
      .req       (req),
      .kill      (kill)
   );

   hbc_bypass_filter #(
      .FILT_CYC (FILT_CYC)
   ) u_filter (
      .clk      (clk),
      .rst_n    (rst_n),
      .req      (bypass_req),
      .byp_act  (byp_act),
      .byp_exit (byp_exit)
   );

   for (genvar i = 0; i < LEGS; i++) begin : g_leg
      hbc_leg #(
         .DEAD_CYC (DEAD_CYC)
      ) u_leg (
         .clk      (clk),
         .rst_n    (rst_n),
         .req      (req[i]),
         .kill     (kill),
         .byp_act  (byp_act),
         .byp_exit (byp_exit),
         .gate     (gate[i])
      );
      assign hs_gate[i] = gate[i].hi;
      assign ls_gate[i] = gate[i].lo;
   end

   // R2: a low enable shows up on every gate in the same cycle
   assert_enable_blank_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !enable |-> (hs_gate == '0) && (ls_gate == '0));

endmodule

// File: tb/tb_hb_gate_ctrl.sv
`timescale 1ns/100ps
module tb_hb_gate_ctrl;

   localparam int unsigned LEGS = 2;
   localparam int unsigned DT   = 5;
   localparam int unsigned FT   = 20;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            enable = 1'b0;
   logic            force_off = 1'b0;
   logic            bypass_req = 1'b0;
   logic [LEGS-1:0] hs_cmd_n = '1;
   logic [LEGS-1:0] ls_cmd = '0;
   logic [LEGS-1:0] hs_gate;
   logic [LEGS-1:0] ls_gate;

   always #2 clk = ~clk;

   hb_gate_ctrl #(
      .LEGS     (LEGS),
      .DEAD_CYC (DT),
      .FILT_CYC (FT)
   ) dut (
      .clk        (clk),
      .rst_n      (rst_n),
      .enable     (enable),
      .force_off  (force_off),
      .bypass_req (bypass_req),
      .hs_cmd_n   (hs_cmd_n),
      .ls_cmd     (ls_cmd),
      .hs_gate    (hs_gate),
      .ls_gate    (ls_gate)
   );

   typedef struct {
      logic [LEGS-1:0] eh;
      logic [LEGS-1:0] el;
      string           tag;
   } exp_t;

   exp_t sb_q[$];
   int   n_checks = 0;
   int   n_errors = 0;
   bit   done = 1'b0;

   task automatic compare(input logic [LEGS-1:0] eh, el, input string tag);
      n_checks++;
      if (hs_gate !== eh || ls_gate !== el) begin
         n_errors++;
         $display("FAIL %s: actual hs=%b ls=%b expected hs=%b ls=%b at %0t",
                  tag, hs_gate, ls_gate, eh, el, $time);
      end
   endtask

   // monitor: pops one expected item after each edge
   always @(negedge clk) begin
      if (sb_q.size() > 0) begin
         exp_t it;
         it = sb_q.pop_front();
         compare(it.eh, it.el, it.tag);
      end
   end

   // driver: expected gates after the next edge with current inputs
   task automatic cyc(input logic [LEGS-1:0] eh, el, input string tag);
      exp_t it;
      it.eh = eh; it.el = el; it.tag = tag;
      sb_q.push_back(it);
      @(posedge clk);
      #3;
   endtask

   task automatic dead_wait(input int n, input logic [LEGS-1:0] wh, wl,
                            input logic [LEGS-1:0] fh, fl, input string tag);
      for (int k = 0; k < n; k++) cyc(wh, wl, tag);
      cyc(fh, fl, tag);
   endtask

   task automatic direct(input logic [LEGS-1:0] eh, el, input string tag);
      #0.5;
      compare(eh, el, tag);
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
         $finish;
      end
   endtask

   initial begin
      #(100000 * 4);
      n_checks++;
      n_errors++;
      $display("FAIL R10 watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      @(posedge clk); #3;
      // R10: gates stay low during reset
      cyc(2'b00, 2'b00, "R10 reset");
      cyc(2'b00, 2'b00, "R10 reset");
      rst_n = 1'b1;
      cyc(2'b00, 2'b00, "R10 idle");

      // R2: request while disabled has no effect
      hs_cmd_n = 2'b10;
      cyc(2'b00, 2'b00, "R2 disabled");

      // R1 R10: first request honoured at once
      enable = 1'b1;
      cyc(2'b01, 2'b00, "R1 R10 leg0 high on");
      ls_cmd = 2'b10;
      cyc(2'b01, 2'b10, "R1 leg1 low on");

      // R4: conflict on leg0 holds
      ls_cmd = 2'b11;
      cyc(2'b01, 2'b10, "R4 conflict hold");
      cyc(2'b01, 2'b10, "R4 conflict hold");

      // R5: leg0 moves high to low with a gap
      hs_cmd_n = 2'b11;
      dead_wait(DT, 2'b00, 2'b10, 2'b00, 2'b11, "R5 gap");

      // R6: tie leg1 commands, drive low -> high switch
      hs_cmd_n = 2'b01; ls_cmd = 2'b01;
      dead_wait(DT, 2'b00, 2'b01, 2'b10, 2'b01, "R6 tied");

      // R3: force-off blanks in the same cycle
      force_off = 1'b1;
      direct(2'b00, 2'b00, "R3 immediate");
      cyc(2'b00, 2'b00, "R3 held");
      force_off = 1'b0;
      dead_wait(DT - 1, 2'b00, 2'b00, 2'b10, 2'b01, "R3 restart");

      // R2: enable low blanks in the same cycle
      enable = 1'b0;
      direct(2'b00, 2'b00, "R2 immediate");
      cyc(2'b00, 2'b00, "R2 held");
      enable = 1'b1;
      dead_wait(DT - 1, 2'b00, 2'b00, 2'b10, 2'b01, "R2 restart");

      // R7: short bypass pulse is ignored
      bypass_req = 1'b1;
      for (int k = 0; k < FT - 1; k++) cyc(2'b10, 2'b01, "R7 short pulse");
      bypass_req = 1'b0;
      hs_cmd_n = 2'b00; ls_cmd = 2'b01;
      cyc(2'b10, 2'b01, "R7 still protected");

      // R7 R8: full bypass, leg0 both on
      bypass_req = 1'b1;
      dead_wait(FT, 2'b10, 2'b01, 2'b11, 2'b01, "R7 R8 engage");

      // R8: leg1 swaps switches at one edge
      hs_cmd_n = 2'b10; ls_cmd = 2'b11;
      cyc(2'b01, 2'b11, "R8 no gap");
      hs_cmd_n = 2'b11;
      cyc(2'b00, 2'b11, "R8 follow");

      // R9: exit clears and reapplies the gap
      bypass_req = 1'b0;
      hs_cmd_n = 2'b10; ls_cmd = 2'b10;
      cyc(2'b00, 2'b00, "R9 exit clear");
      dead_wait(DT - 1, 2'b00, 2'b00, 2'b01, 2'b10, "R9 resume");

      // R1: withdrawing requests drops gates at the next edge
      hs_cmd_n = 2'b11; ls_cmd = 2'b00;
      cyc(2'b00, 2'b00, "R1 release");

      @(posedge clk); #3;
      finish_run();
   end

endmodule